// File: doc/BRIEF.md
# Barrel Multithreaded Stack Processor

This block is a stack-machine core whose single datapath is shared by eight independent hardware threads. A slot counter hands the datapath to the next thread on every clock, in a fixed rotation. Each thread therefore issues one instruction every eight cycles. Each thread has its own program counter, top-of-stack register, data stack pointer and return stack pointer. The stack entries below the top live in two shared synchronous RAMs, one for data and one for return addresses, split into one region per thread.

Every instruction passes through four stages: fetch, stack read, execute and write-back. The rotation puts a different thread in each stage, so a thread's instruction has fully written back before that thread fetches again. The core therefore needs no forwarding and no hazard logic. The instruction memory is a synchronous read port. The data memory has one synchronous read port and one write port. A debug selector shows the program counter and top of stack of any one thread.

Top module: `barrelStackCore`

## Requirements
- R1: While reset is asserted and right after it, thread k (0..7) holds program counter k*64, and its top of stack and both stack pointers are zero.
- R2: In the n-th cycle after reset release, `imemAddr` carries the program counter of thread n mod 8. Each thread fetches exactly once in every eight cycles.
- R3: Threads do not disturb one another. A thread's instruction completes before that thread's next fetch, so the next instruction sees its result.
- R4: An instruction is 16 bits, with the opcode in bits [15:11] and an 11-bit immediate in bits [10:0]. The opcodes are NOP=0, LIT=1, ADD=2, AND=3, XOR=4, DUP=5, DROP=6, SWAP=7, TOR=8, FROMR=9, FETCH=10, STORE=11, JMP=12, JZ=13, CALL=14, RET=15. Any other code acts as NOP.
- R5: LIT pushes the zero-extended immediate. ADD, AND and XOR pop two operands and push the result. DUP copies the top. DROP removes the top. SWAP exchanges the top two entries.
- R6: TOR moves the top of the data stack onto the return stack. FROMR moves the top of the return stack into the data stack's top, pushing the old top down.
- R7: FETCH replaces the top with the data word at the address in its low 8 bits. STORE writes the second entry to the address in the top, then pops only the address, so the stored value becomes the new top.
- R8: JMP loads the immediate into the program counter. JZ pops the top and jumps to the immediate only if the popped value was zero. CALL pushes the next address on the return stack and jumps. RET pops the return stack into the program counter.
- R9: Each data stack and return stack has 16 RAM entries below the top register, and its pointer wraps modulo 16. Overflow and underflow raise no error and silently overwrite or reread old entries.
- R10: A data read is issued in the stack-read stage, and its word is used one cycle later, in the execute stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| imemAddr | output | 9 | Instruction fetch address of the thread in the fetch slot |
| imemData | input | 16 | Instruction word, one cycle after its address |
| dmemRdEn | output | 1 | Data read strobe |
| dmemRdAddr | output | 8 | Data read address |
| dmemRdata | input | 16 | Data read word, one cycle after the strobe |
| dmemWe | output | 1 | Data write strobe |
| dmemWrAddr | output | 8 | Data write address |
| dmemWdata | output | 16 | Data write word |
| dbgSel | input | 3 | Thread chosen for the debug view |
| dbgPc | output | 9 | Program counter of the chosen thread |
| dbgTos | output | 16 | Top of stack of the chosen thread |

## Verification
Two situations are hard to reach from the ports. One is showing that eight interleaved threads never see each other's stack state. The other is showing the silent wrap of a stack that has run past 16 entries. The stimulus loads all eight threads at once with the same program shape but different constants, and each thread stores its intermediate results into its own region of data memory. Any mix-up between threads then shows up as a wrong value at an address. A second program pushes 18 literals and pops 17. After the wrap, the top that is left differs from the value an unbounded stack would give.

// File: rtl/bsPkg.sv
package bsPkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP = 5'd0, OP_LIT = 5'd1, OP_ADD = 5'd2, OP_AND = 5'd3,
    OP_XOR = 5'd4, OP_DUP = 5'd5, OP_DROP = 5'd6, OP_SWAP = 5'd7,
    OP_TOR = 5'd8, OP_FROMR = 5'd9, OP_FETCH = 5'd10, OP_STORE = 5'd11,
    OP_JMP = 5'd12, OP_JZ = 5'd13, OP_CALL = 5'd14, OP_RET = 5'd15
  } opT;

  // source feeding the per-thread top-of-stack register
  typedef enum logic [2:0] {
    TS_KEEP, TS_IMM, TS_ADD, TS_AND, TS_XOR, TS_NOS, TS_RSTK, TS_MEM
  } tosSelT;

  typedef enum logic [1:0] {PS_NEXT, PS_IMM, PS_ZERO, PS_RET} pcSelT;

  // strobes from control to datapath
  typedef struct packed {
    logic   dPush;   // old top written at dsp+1, dsp increments
    logic   dPop;    // dsp decrements
    logic   dWrNos;  // old top written at dsp (swap)
    logic   rPush;   // return stack push at rsp+1
    logic   rPop;    // return stack pop
    logic   rFromPc; // pushed return value is pc+1 instead of top
    logic   memRd;
    logic   memWr;
    tosSelT tosSel;
    pcSelT  pcSel;
  } ctlT;
endpackage

// File: rtl/bsCtrl.sv
module bsCtrl
  import bsPkg::*;
#(
  parameter int TH_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [OP_W-1:0]     opField,
  output logic [TH_W-1:0]     slot,
  output ctlT                 ctl
);

  // round-robin issue slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) slot <= '0;
    else       slot <= slot + 1'b1;
  end

  // instruction decode for the stack-read stage
  always_comb begin
    ctl = '0;
    ctl.tosSel = TS_KEEP;
    ctl.pcSel  = PS_NEXT;
    case (opField)
      OP_LIT:   begin ctl.dPush = 1'b1; ctl.tosSel = TS_IMM; end
      OP_ADD:   begin ctl.dPop = 1'b1; ctl.tosSel = TS_ADD; end
      OP_AND:   begin ctl.dPop = 1'b1; ctl.tosSel = TS_AND; end
      OP_XOR:   begin ctl.dPop = 1'b1; ctl.tosSel = TS_XOR; end
      OP_DUP:   begin ctl.dPush = 1'b1; end
      OP_DROP:  begin ctl.dPop = 1'b1; ctl.tosSel = TS_NOS; end
      OP_SWAP:  begin ctl.dWrNos = 1'b1; ctl.tosSel = TS_NOS; end
      OP_TOR:   begin ctl.dPop = 1'b1; ctl.rPush = 1'b1; ctl.tosSel = TS_NOS; end
      OP_FROMR: begin ctl.dPush = 1'b1; ctl.rPop = 1'b1; ctl.tosSel = TS_RSTK; end
      OP_FETCH: begin ctl.memRd = 1'b1; ctl.tosSel = TS_MEM; end
      OP_STORE: begin ctl.memWr = 1'b1; ctl.dPop = 1'b1; ctl.tosSel = TS_NOS; end
      OP_JMP:   begin ctl.pcSel = PS_IMM; end
      OP_JZ:    begin ctl.dPop = 1'b1; ctl.tosSel = TS_NOS; ctl.pcSel = PS_ZERO; end
      OP_CALL:  begin ctl.rPush = 1'b1; ctl.rFromPc = 1'b1; ctl.pcSel = PS_IMM; end
      OP_RET:   begin ctl.rPop = 1'b1; ctl.pcSel = PS_RET; end
      default:  ;
    endcase
  end

endmodule

// File: rtl/bsDatapath.sv
module bsDatapath
  import bsPkg::*;
#(
  parameter int THREADS   = 8,
  parameter int TH_W      = 3,
  parameter int DW        = 16,
  parameter int PC_W      = 9,
  parameter int SP_W      = 4,
  parameter int DA_W      = 8,
  parameter int IMM_W     = 11,
  parameter int PC_STRIDE = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TH_W-1:0]   slot,
  input  ctlT               ctl,
  input  logic [IMM_W-1:0]  imm,
  output logic [PC_W-1:0]   imemAddr,
  output logic              dmemRdEn,
  output logic [DA_W-1:0]   dmemRdAddr,
  input  logic [DW-1:0]     dmemRdata,
  output logic              dmemWe,
  output logic [DA_W-1:0]   dmemWrAddr,
  output logic [DW-1:0]     dmemWdata,
  input  logic [TH_W-1:0]   dbgSel,
  output logic [PC_W-1:0]   dbgPc,
  output logic [DW-1:0]     dbgTos
);

  localparam int RA_W  = TH_W + SP_W;
  localparam int RAM_N = THREADS << SP_W;

  // per-thread architectural state
  logic [PC_W-1:0] pcR  [THREADS];
  logic [DW-1:0]   tosR [THREADS];
  logic [SP_W-1:0] dspR [THREADS];
  logic [SP_W-1:0] rspR [THREADS];

  // shared stack storage, one region per thread
  logic [DW-1:0] dsRam [RAM_N];
  logic [DW-1:0] rsRam [RAM_N];

  // stage registers
  logic            v1, v2, v3;
  logic [TH_W-1:0] th1, th2, th3;
  logic [PC_W-1:0] pc2;
  logic [IMM_W-1:0] imm2;
  ctlT             ctl2;
  logic [DW-1:0]   tos2, dsQ, rsQ;
  logic [SP_W-1:0] dsp2, rsp2;

  // execute results
  logic [PC_W-1:0] pcInc, pcN, pcN3;
  logic [DW-1:0]   tosN, tosN3, dsWd, dsWd3, rsWd, rsWd3;
  logic [SP_W-1:0] dspUp, dspDn, rspUp, rspDn, dspN, dspN3, rspN, rspN3;
  logic            dsWe, dsWe3, rsWe, rsWe3;
  logic [RA_W-1:0] dsWa, dsWa3, rsWa, rsWa3;

  // fetch
  assign imemAddr = pcR[slot];

  // stack-read stage issues data reads from the thread's top
  assign dmemRdEn   = v1 & ctl.memRd;
  assign dmemRdAddr = tosR[th1][DA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      th1 <= '0; th2 <= '0; th3 <= '0;
      pc2 <= '0; imm2 <= '0; ctl2 <= '0; tos2 <= '0; dsp2 <= '0; rsp2 <= '0;
      pcN3 <= '0; tosN3 <= '0; dspN3 <= '0; rspN3 <= '0;
      dsWe3 <= 1'b0; dsWa3 <= '0; dsWd3 <= '0;
      rsWe3 <= 1'b0; rsWa3 <= '0; rsWd3 <= '0;
    end else begin
      // fetch -> stack read
      v1  <= 1'b1;
      th1 <= slot;
      // stack read -> execute
      v2   <= v1;
      th2  <= th1;
      pc2  <= pcR[th1];
      imm2 <= imm;
      ctl2 <= ctl;
      tos2 <= tosR[th1];
      dsp2 <= dspR[th1];
      rsp2 <= rspR[th1];
      // execute -> write-back
      v3    <= v2;
      th3   <= th2;
      pcN3  <= pcN;
      tosN3 <= tosN;
      dspN3 <= dspN;
      rspN3 <= rspN;
      dsWe3 <= dsWe; dsWa3 <= dsWa; dsWd3 <= dsWd;
      rsWe3 <= rsWe; rsWa3 <= rsWa; rsWd3 <= rsWd;
    end
  end

  // stack RAMs: one read in stack-read, one write in write-back
  always_ff @(posedge clk) begin
    dsQ <= dsRam[{th1, dspR[th1]}];
    rsQ <= rsRam[{th1, rspR[th1]}];
    if (v3 && dsWe3) dsRam[dsWa3] <= dsWd3;
    if (v3 && rsWe3) rsRam[rsWa3] <= rsWd3;
  end

  // execute
  always_comb begin
    pcInc = pc2 + 1'b1;
    dspUp = dsp2 + 1'b1;
    dspDn = dsp2 - 1'b1;
    rspUp = rsp2 + 1'b1;
    rspDn = rsp2 - 1'b1;

    case (ctl2.tosSel)
      TS_IMM:  tosN = {{(DW-IMM_W){1'b0}}, imm2};
      TS_ADD:  tosN = dsQ + tos2;
      TS_AND:  tosN = dsQ & tos2;
      TS_XOR:  tosN = dsQ ^ tos2;
      TS_NOS:  tosN = dsQ;
      TS_RSTK: tosN = rsQ;
      TS_MEM:  tosN = dmemRdata;
      default: tosN = tos2;
    endcase

    dspN = ctl2.dPush ? dspUp : (ctl2.dPop ? dspDn : dsp2);
    dsWe = ctl2.dPush | ctl2.dWrNos;
    dsWa = {th2, (ctl2.dPush ? dspUp : dsp2)};
    dsWd = tos2;

    rspN = ctl2.rPush ? rspUp : (ctl2.rPop ? rspDn : rsp2);
    rsWe = ctl2.rPush;
    rsWa = {th2, rspUp};
    rsWd = ctl2.rFromPc ? {{(DW-PC_W){1'b0}}, pcInc} : tos2;

    case (ctl2.pcSel)
      PS_IMM:  pcN = imm2[PC_W-1:0];
      PS_ZERO: pcN = (tos2 == '0) ? imm2[PC_W-1:0] : pcInc;
      PS_RET:  pcN = rsQ[PC_W-1:0];
      default: pcN = pcInc;
    endcase
  end

  // store in execute: value is the entry below the top
  assign dmemWe     = v2 & ctl2.memWr;
  assign dmemWrAddr = tos2[DA_W-1:0];
  assign dmemWdata  = dsQ;

  // write-back of per-thread registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < THREADS; k++) begin
        pcR[k]  <= PC_W'(k * PC_STRIDE);
        tosR[k] <= '0;
        dspR[k] <= '0;
        rspR[k] <= '0;
      end
    end else if (v3) begin
      pcR[th3]  <= pcN3;
      tosR[th3] <= tosN3;
      dspR[th3] <= dspN3;
      rspR[th3] <= rspN3;
    end
  end

  assign dbgPc  = pcR[dbgSel];
  assign dbgTos = tosR[dbgSel];

  // the thread writing back is the one fetched three slots earlier
  p_lockstep_r2: assert property (@(posedge clk) disable iff (!rstN)
    v3 |-> th3 == $past(slot, 3));

  // no thread has two instructions in flight
  p_distinct_r3: assert property (@(posedge clk) disable iff (!rstN)
    v3 |-> (th3 != th2) && (th3 != th1) && (th2 != th1));

  // RAM write of one thread never lands on the entry another reads
  p_ram_port_r4: assert property (@(posedge clk) disable iff (!rstN)
    (v3 && dsWe3) |-> dsWa3 != {th1, dspR[th1]});

  // stack pointers move by at most one entry, wrapping modulo the depth
  p_sp_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    v3 |-> (SP_W'(dspN3 - dspR[th3]) == '0) || (SP_W'(dspN3 - dspR[th3]) == SP_W'(1))
           || (SP_W'(dspN3 - dspR[th3]) == '1));

endmodule

// File: rtl/barrelStackCore.sv
module barrelStackCore
  import bsPkg::*;
#(
  parameter int THREADS     = 8,
  parameter int DW          = 16,
  parameter int IW          = 16,
  parameter int PC_W        = 9,
  parameter int DA_W        = 8,
  parameter int STACK_DEPTH = 16,
  parameter int PC_STRIDE   = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  output logic [PC_W-1:0]            imemAddr,
  input  logic [IW-1:0]              imemData,
  output logic                       dmemRdEn,
  output logic [DA_W-1:0]            dmemRdAddr,
  input  logic [DW-1:0]              dmemRdata,
  output logic                       dmemWe,
  output logic [DA_W-1:0]            dmemWrAddr,
  output logic [DW-1:0]              dmemWdata,
  input  logic [$clog2(THREADS)-1:0] dbgSel,
  output logic [PC_W-1:0]            dbgPc,
  output logic [DW-1:0]              dbgTos
);

  localparam int TH_W  = $clog2(THREADS);
  localparam int SP_W  = $clog2(STACK_DEPTH);
  localparam int IMM_W = IW - OP_W;

  logic [TH_W-1:0] slot;
  ctlT             ctl;

  bsCtrl #(.TH_W(TH_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .opField (imemData[IW-1 -: OP_W]),
    .slot    (slot),
    .ctl     (ctl)
  );

  bsDatapath #(
    .THREADS(THREADS), .TH_W(TH_W), .DW(DW), .PC_W(PC_W), .SP_W(SP_W),
    .DA_W(DA_W), .IMM_W(IMM_W), .PC_STRIDE(PC_STRIDE)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .slot       (slot),
    .ctl        (ctl),
    .imm        (imemData[IMM_W-1:0]),
    .imemAddr   (imemAddr),
    .dmemRdEn   (dmemRdEn),
    .dmemRdAddr (dmemRdAddr),
    .dmemRdata  (dmemRdata),
    .dmemWe     (dmemWe),
    .dmemWrAddr (dmemWrAddr),
    .dmemWdata  (dmemWdata),
    .dbgSel     (dbgSel),
    .dbgPc      (dbgPc),
    .dbgTos     (dbgTos)
  );

endmodule

// File: tb/tb_barrelStackCore.sv
`timescale 1ns/1ps
module tb_barrelStackCore;
  localparam int I_NOP = 0, I_LIT = 1, I_ADD = 2, I_AND = 3, I_XOR = 4, I_DUP = 5,
                 I_DROP = 6, I_SWAP = 7, I_TOR = 8, I_FROMR = 9, I_FET = 10,
                 I_STO = 11, I_JMP = 12, I_JZ = 13, I_CALL = 14, I_RET = 15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  imemAddr;
  logic [15:0] imemData = '0;
  logic        dmemRdEn, dmemWe;
  logic [7:0]  dmemRdAddr, dmemWrAddr;
  logic [15:0] dmemRdata = '0, dmemWdata;
  logic [2:0]  dbgSel = '0;
  logic [8:0]  dbgPc;
  logic [15:0] dbgTos;

  logic [15:0] imem [512];
  logic [15:0] dm   [256];
  int nChk = 0, nBad = 0;
  bit done = 0;

  barrelStackCore dut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) imemData <= imem[imemAddr];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) dm[i] <= '0;
    end else begin
      if (dmemWe) dm[dmemWrAddr] <= dmemWdata;
      if (dmemRdEn) dmemRdata <= dm[dmemRdAddr];
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(inout int a, input int op, input int im);
    imem[a] = {op[4:0], im[10:0]};
    a++;
  endtask

  task automatic clearImem();
    for (int i = 0; i < 512; i++) imem[i] = '0;
  endtask

  // program A: arithmetic, stacks, memory, branches
  task automatic loadA(input int k);
    int b, a, m;
    b = k * 64; a = b; m = k * 16;
    put(a, I_LIT, 5 + 3*k); put(a, I_LIT, 'h100 + k); put(a, I_ADD, 0);
    put(a, I_LIT, m); put(a, I_STO, 0);
    put(a, I_DUP, 0); put(a, I_LIT, 'hF0 + k); put(a, I_XOR, 0);
    put(a, I_LIT, m + 1); put(a, I_STO, 0);
    put(a, I_AND, 0); put(a, I_LIT, m + 2); put(a, I_STO, 0);
    put(a, I_LIT, 'h300 + k); put(a, I_SWAP, 0); put(a, I_LIT, m + 3); put(a, I_STO, 0);
    put(a, I_DROP, 0); put(a, I_LIT, m + 4); put(a, I_STO, 0);
    put(a, I_TOR, 0); put(a, I_LIT, 'h400 + k); put(a, I_FROMR, 0);
    put(a, I_LIT, m + 5); put(a, I_STO, 0);
    put(a, I_DROP, 0); put(a, I_LIT, m + 6); put(a, I_STO, 0);
    put(a, I_LIT, m); put(a, I_FET, 0); put(a, I_LIT, m + 7); put(a, I_STO, 0);
    put(a, I_CALL, b + 50); put(a, I_LIT, m + 8); put(a, I_STO, 0);
    put(a, I_LIT, 0); put(a, I_JZ, b + 38); put(a, I_LIT, 'h111);
    put(a, I_LIT, m + 9); put(a, I_STO, 0);
    put(a, I_LIT, 1); put(a, I_JZ, b + 44); put(a, I_LIT, 'h222); put(a, I_NOP, 0);
    put(a, I_LIT, m + 10); put(a, I_STO, 0);
    put(a, I_JMP, b + 46);
    a = b + 50;
    put(a, I_LIT, 'h500 + k); put(a, I_RET, 0);
  endtask

  // program B: 18 pushes, 17 pops, store the top
  task automatic loadB(input int k);
    int b, a;
    b = k * 64; a = b;
    for (int i = 0; i < 18; i++) put(a, I_LIT, k*100 + i);
    for (int i = 0; i < 17; i++) put(a, I_DROP, 0);
    put(a, I_LIT, k * 16); put(a, I_STO, 0);
    put(a, I_JMP, b + 37);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      nChk++;
      $display("FAIL R3 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int s, e, v;
    int expA [11];
    clearImem();
    for (int k = 0; k < 8; k++) loadA(k);
    repeat (3) @(negedge clk);

    // R1: reset state of every thread
    for (int k = 0; k < 8; k++) begin
      dbgSel = 3'(k); #1;
      chk($sformatf("R1 reset pc t%0d", k), dbgPc, k * 64);
      chk($sformatf("R1 reset tos t%0d", k), dbgTos, 0);
    end

    // R2: rotation of fetch addresses after release
    @(negedge clk) rstN = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (i > 0) @(negedge clk);
      chk($sformatf("R2 fetch cycle %0d", i), imemAddr, (i % 8) * 64 + i / 8);
    end

    repeat (600) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      s = (5 + 3*k) + ('h100 + k);
      e = 'hF0 + k;
      v = s & (s ^ e);
      expA[0] = s; expA[1] = s ^ e; expA[2] = v; expA[3] = v;
      expA[4] = 'h300 + k; expA[5] = 'h300 + k; expA[6] = 'h400 + k;
      expA[7] = s; expA[8] = 'h500 + k; expA[9] = 'h500 + k; expA[10] = 'h222;
      chk($sformatf("R5 add t%0d", k), dm[k*16 + 0], expA[0]);
      chk($sformatf("R5 dup-xor t%0d", k), dm[k*16 + 1], expA[1]);
      chk($sformatf("R5 and t%0d", k), dm[k*16 + 2], expA[2]);
      chk($sformatf("R5 swap t%0d", k), dm[k*16 + 3], expA[3]);
      chk($sformatf("R5 drop t%0d", k), dm[k*16 + 4], expA[4]);
      chk($sformatf("R6 fromr t%0d", k), dm[k*16 + 5], expA[5]);
      chk($sformatf("R6 below t%0d", k), dm[k*16 + 6], expA[6]);
      chk($sformatf("R10 R7 fetch t%0d", k), dm[k*16 + 7], expA[7]);
      chk($sformatf("R8 call-ret t%0d", k), dm[k*16 + 8], expA[8]);
      chk($sformatf("R8 jz taken t%0d", k), dm[k*16 + 9], expA[9]);
      chk($sformatf("R8 jz not taken t%0d", k), dm[k*16 + 10], expA[10]);
      dbgSel = 3'(k); #1;
      chk($sformatf("R3 halt pc t%0d", k), dbgPc, k*64 + 46);
      chk($sformatf("R4 R7 final top t%0d", k), dbgTos, 'h222);
    end

    // R9: wrap of a 16-entry stack
    @(negedge clk) rstN = 1'b0;
    clearImem();
    for (int k = 0; k < 8; k++) loadB(k);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (500) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      // pushes 0..17 leave dsp=2; the 17th pop rereads entry 2, last written by push 17 (value k*100+16)
      chk($sformatf("R9 wrapped store t%0d", k), dm[k*16], k*100 + 16);
      dbgSel = 3'(k); #1;
      chk($sformatf("R9 wrapped top t%0d", k), dbgTos, k*100 + 16);
      chk($sformatf("R3 halt pc B t%0d", k), dbgPc, k*64 + 37);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule